// File: doc/BRIEF.md
# CPU Performance Level Sequencer

This block holds four CPU performance levels, numbered 0 (fastest) to 3. Each level has its own clock-source index and divider. The settings are packed two levels to a 32-bit configuration register. A 2-bit current-level register picks the level in force. While dynamic scaling is enabled, the block drives the source index and divider of that level to the CPU clock path. While scaling is disabled, it drives a static source and divider from a separate register.

Software asks for a rate by presenting a divider value. The block searches the levels for that divider and moves to the first level that holds it. A move from one of the slow levels (2 or 3) straight to level 0 is never made in one step. The block first drops into level 1, holds there for a settle interval of a set number of cycles so that the supply can recover, and only then enters level 0. A busy flag covers this two-step sequence.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset the current level is 0, busy_o and err_o are low, scaling is disabled, and the outputs show the static reset values: source 0 and divider 1.
- R2: Levels 0 and 1 live in the register at 0x18, and levels 2 and 3 in the register at 0x1C. Even levels use bits [31:16] and odd levels use bits [15:0]. Within a half, the divider is at bits [15:13], a clock-select flag at bit 11, and the source index at bits [10:9].
- R3: Bit 31 of the register at 0x24 enables dynamic scaling. When it is set, act_src_o and act_div_o show the fields of the current level, which is read at 0x30 bits [1:0]. When it is clear, they show the static register at 0x00: source at bits [1:0] and divider at bits [4:2].
- R4: A divider request is compared with levels 0, 1, 2 and 3 in that order, and the first level with an equal divider becomes the current level on the next clock edge.
- R5: A request that matches no level, or that arrives while scaling is disabled, raises err_o for exactly one cycle and leaves the current level unchanged.
- R6: A source write takes effect only while scaling is disabled, and it writes the same index into all four levels. While scaling is enabled, a source write raises err_o for one cycle and changes no register.
- R7: A request that resolves to level 0 while the current level is 2 or 3 first sets the level to 1. The block holds level 1 for exactly SETTLE_CYCLES cycles and then sets level 0.
- R8: busy_o is high for the whole of the level-1 hold. While busy_o is high, divider requests, source writes and bus writes to 0x30 are ignored.
- R9: During a stepped move, the current level takes only the values 1 and then 0, and each changes once.
- R10: A request that resolves to level 0 from level 1, or any request that resolves to a level other than 0, completes in one step without raising busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | Divider request strobe |
| req_div_i | input | 3 | Requested divider |
| src_valid_i | input | 1 | Source-index write strobe |
| src_sel_i | input | 2 | Source index written to all levels |
| act_src_o | output | 2 | Active clock-source index |
| act_div_o | output | 3 | Active divider |
| busy_o | output | 1 | Stepped move in progress |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
Several level tables are used for divider requests. One holds a unique divider per level. One repeats a divider in levels 1 and 2, which shows whether the search is first-match in ascending order or last-match. One request matches no level, which separates a rejection from a silent hold. Moves to level 0 are made from level 3 and from level 1, which tells the stepped path from the direct one. The bench samples busy_o and the current level on every cycle of the hold, so it catches a hold that is too short or too long and any extra level value. Stimulus that arrives during the hold must leave the sequence unchanged. Source writes are sent with scaling both off and on, and both register halves are read back.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef logic [1:0] lvl_t;

  localparam int NLVL     = 4;
  localparam int DIV_W    = 3;
  localparam int SRC_W    = 2;
  localparam int HALF_W   = 16;
  localparam int DIV_LSB  = 13;
  localparam int CSEL_LSB = 11;
  localparam int SRC_LSB  = 9;
  localparam int DFS_BIT  = 31;

  localparam logic [7:0] A_STATIC = 8'h00;
  localparam logic [7:0] A_CFG01  = 8'h18;
  localparam logic [7:0] A_CFG23  = 8'h1C;
  localparam logic [7:0] A_MODE   = 8'h24;
  localparam logic [7:0] A_LOAD   = 8'h30;

  function automatic logic [HALF_W-1:0] pack_half(logic [DIV_W-1:0] d, logic [SRC_W-1:0] s);
    logic [HALF_W-1:0] h;
    h = '0;
    h[DIV_LSB +: DIV_W] = d;
    h[SRC_LSB +: SRC_W] = s;
    return h;
  endfunction
endpackage

// File: rtl/dvfs_cfg_regs.sv
module dvfs_cfg_regs
  import dvfs_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  input  logic                    src_wr_i,
  input  logic [SRC_W-1:0]        src_sel_i,
  input  lvl_t                    cur_lvl_i,
  output logic [31:0]             rdata_o,
  output logic                    dfs_en_o,
  output logic [SRC_W-1:0]        stat_src_o,
  output logic [DIV_W-1:0]        stat_div_o,
  output logic [NLVL*DIV_W-1:0]   lvl_div_o,
  output logic [NLVL*SRC_W-1:0]   lvl_src_o
);
  localparam logic [31:0] CFG01_RST  = {pack_half(3'd1, 2'd0), pack_half(3'd2, 2'd0)};
  localparam logic [31:0] CFG23_RST  = {pack_half(3'd4, 2'd0), pack_half(3'd6, 2'd0)};
  localparam logic [31:0] STATIC_RST = 32'h0000_0004;

  logic [31:0] cfg01_q, cfg23_q, static_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg01_q  <= CFG01_RST;
      cfg23_q  <= CFG23_RST;
      static_q <= STATIC_RST;
      mode_q   <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_STATIC: static_q <= wdata_i;
          A_CFG01:  cfg01_q  <= wdata_i;
          A_CFG23:  cfg23_q  <= wdata_i;
          A_MODE:   mode_q   <= wdata_i;
          default: ;
        endcase
      end
      // broadcast overrides the source bits of a same-cycle bus write
      if (src_wr_i) begin
        cfg01_q[HALF_W+SRC_LSB +: SRC_W] <= src_sel_i;
        cfg01_q[SRC_LSB +: SRC_W]        <= src_sel_i;
        cfg23_q[HALF_W+SRC_LSB +: SRC_W] <= src_sel_i;
        cfg23_q[SRC_LSB +: SRC_W]        <= src_sel_i;
      end
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int HB = (l % 2 == 0) ? HALF_W : 0;
    logic [31:0] word;
    assign word = (l < 2) ? cfg01_q : cfg23_q;
    assign lvl_div_o[l*DIV_W +: DIV_W] = word[HB+DIV_LSB +: DIV_W];
    assign lvl_src_o[l*SRC_W +: SRC_W] = word[HB+SRC_LSB +: SRC_W];
  end

  assign dfs_en_o   = mode_q[DFS_BIT];
  assign stat_src_o = static_q[SRC_W-1:0];
  assign stat_div_o = static_q[SRC_W +: DIV_W];

  always_comb begin
    case (addr_i)
      A_STATIC: rdata_o = static_q;
      A_CFG01:  rdata_o = cfg01_q;
      A_CFG23:  rdata_o = cfg23_q;
      A_MODE:   rdata_o = mode_q;
      A_LOAD:   rdata_o = {30'b0, cur_lvl_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dvfs_level_match.sv
module dvfs_level_match
  import dvfs_pkg::*;
(
  input  logic [NLVL*DIV_W-1:0] lvl_div_i,
  input  logic [DIV_W-1:0]      req_div_i,
  output logic                  hit_o,
  output lvl_t                  hit_lvl_o
);
  // descending scan so the lowest matching level is the one kept
  always_comb begin
    hit_o     = 1'b0;
    hit_lvl_o = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (lvl_div_i[l*DIV_W +: DIV_W] == req_div_i) begin
        hit_o     = 1'b1;
        hit_lvl_o = lvl_t'(l);
      end
    end
  end
endmodule

// File: rtl/dvfs_step_seq.sv
module dvfs_step_seq
  import dvfs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dfs_en_i,
  input  logic req_valid_i,
  input  logic hit_i,
  input  lvl_t hit_lvl_i,
  input  logic src_valid_i,
  input  logic load_wr_i,
  input  lvl_t load_val_i,
  output lvl_t cur_lvl_o,
  output logic busy_o,
  output logic err_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_lvl_o <= '0;
      busy_o    <= 1'b0;
      err_o     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      err_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          cur_lvl_o <= 2'd0;
          busy_o    <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        if (src_valid_i && dfs_en_i) err_o <= 1'b1;
        if (req_valid_i) begin
          if (!dfs_en_i || !hit_i) begin
            err_o <= 1'b1;
          end else if (hit_lvl_i == 2'd0 && cur_lvl_o[1]) begin
            cur_lvl_o <= 2'd1;
            busy_o    <= 1'b1;
            cnt_q     <= CNT_W'(SETTLE_CYCLES - 1);
          end else begin
            cur_lvl_o <= hit_lvl_i;
          end
        end else if (load_wr_i) begin
          cur_lvl_o <= load_val_i;
        end
      end
    end
  end
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
  import dvfs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        req_valid_i,
  input  logic [2:0]  req_div_i,
  input  logic        src_valid_i,
  input  logic [1:0]  src_sel_i,
  output logic [1:0]  act_src_o,
  output logic [2:0]  act_div_o,
  output logic        busy_o,
  output logic        err_o
);
  logic                  dfs_en, hit;
  lvl_t                  hit_lvl, cur_lvl;
  logic [SRC_W-1:0]      stat_src;
  logic [DIV_W-1:0]      stat_div;
  logic [NLVL*DIV_W-1:0] lvl_div;
  logic [NLVL*SRC_W-1:0] lvl_src;
  logic                  src_wr, load_wr;

  assign src_wr  = src_valid_i && !dfs_en && !busy_o;
  assign load_wr = bus_we_i && (bus_addr_i == A_LOAD);

  dvfs_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .src_wr_i   (src_wr),
    .src_sel_i  (src_sel_i),
    .cur_lvl_i  (cur_lvl),
    .rdata_o    (bus_rdata_o),
    .dfs_en_o   (dfs_en),
    .stat_src_o (stat_src),
    .stat_div_o (stat_div),
    .lvl_div_o  (lvl_div),
    .lvl_src_o  (lvl_src)
  );

  dvfs_level_match u_match (
    .lvl_div_i (lvl_div),
    .req_div_i (req_div_i),
    .hit_o     (hit),
    .hit_lvl_o (hit_lvl)
  );

  dvfs_step_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dfs_en_i    (dfs_en),
    .req_valid_i (req_valid_i),
    .hit_i       (hit),
    .hit_lvl_i   (hit_lvl),
    .src_valid_i (src_valid_i),
    .load_wr_i   (load_wr),
    .load_val_i  (bus_wdata_i[1:0]),
    .cur_lvl_o   (cur_lvl),
    .busy_o      (busy_o),
    .err_o       (err_o)
  );

  always_comb begin
    if (dfs_en) begin
      act_src_o = lvl_src[int'(cur_lvl)*SRC_W +: SRC_W];
      act_div_o = lvl_div[int'(cur_lvl)*DIV_W +: DIV_W];
    end else begin
      act_src_o = stat_src;
      act_div_o = stat_div;
    end
  end
endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk #(
  parameter int SETTLE_CYCLES = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       err_i,
  input logic [1:0] level_i
);
  logic [15:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else         busy_cnt_q <= busy_i ? busy_cnt_q + 16'd1 : 16'd0;
  end

  assert_err_keeps_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $stable(level_i));

  assert_busy_holds_l1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> level_i == 2'd1);

  assert_entry_from_slow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(level_i[1]));

  assert_exit_to_l0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> level_i == 2'd0);

  assert_settle_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt_q == 16'(SETTLE_CYCLES));

  assert_no_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_cnt_q < 16'(SETTLE_CYCLES));
endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_o),
  .err_i   (err_o),
  .level_i (cur_lvl)
);

// File: tb/tb_dvfs_level_ctrl.sv
module tb_dvfs_level_ctrl;
  localparam int SETTLE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_div = '0;
  logic        src_valid = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [1:0]  act_src;
  logic [2:0]  act_div;
  logic        busy, err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dvfs_level_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .req_valid_i(req_valid), .req_div_i(req_div),
    .src_valid_i(src_valid), .src_sel_i(src_sel),
    .act_src_o(act_src), .act_div_o(act_div), .busy_o(busy), .err_o(err)
  );

  function automatic logic [15:0] half(logic [2:0] d, logic [1:0] s);
    return (16'(d) << 13) | (16'(s) << 9);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic request(logic [2:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_div = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h30, v);
    chk("R1 level", v, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 src", 32'(act_src), 0);
    chk("R1 div", 32'(act_div), 1);
  endtask

  task automatic t_static;
    wr(8'h00, (32'd5 << 2) | 32'd2);
    chk("R3 static src", 32'(act_src), 2);
    chk("R3 static div", 32'(act_div), 5);
  endtask

  task automatic t_src_broadcast;
    logic [31:0] v;
    @(negedge clk);
    src_valid = 1'b1; src_sel = 2'd3;
    @(negedge clk);
    src_valid = 1'b0;
    chk("R6 no err when disabled", 32'(err), 0);
    rd(8'h18, v);
    chk("R6 R2 cfg01 broadcast", v, {half(3'd1, 2'd3), half(3'd2, 2'd3)});
    rd(8'h1C, v);
    chk("R6 R2 cfg23 broadcast", v, {half(3'd4, 2'd3), half(3'd6, 2'd3)});
  endtask

  task automatic t_enable;
    wr(8'h24, 32'h8000_0000);
    chk("R3 level0 src", 32'(act_src), 3);
    chk("R3 level0 div", 32'(act_div), 1);
  endtask

  task automatic t_src_rejected;
    logic [31:0] v;
    @(negedge clk);
    src_valid = 1'b1; src_sel = 2'd1;
    @(negedge clk);
    src_valid = 1'b0;
    chk("R6 err when enabled", 32'(err), 1);
    rd(8'h18, v);
    chk("R6 cfg01 untouched", v, {half(3'd1, 2'd3), half(3'd2, 2'd3)});
    @(negedge clk);
    chk("R5 err one cycle", 32'(err), 0);
  endtask

  task automatic t_req_unique;
    logic [31:0] v;
    request(3'd4);
    rd(8'h30, v);
    chk("R4 unique match level", v, 2);
    chk("R4 div out", 32'(act_div), 4);
    chk("R10 no busy", 32'(busy), 0);
    chk("R4 no err", 32'(err), 0);
  endtask

  task automatic t_req_first_match;
    logic [31:0] v;
    wr(8'h18, {half(3'd1, 2'd0), half(3'd3, 2'd1)});
    wr(8'h1C, {half(3'd3, 2'd2), half(3'd5, 2'd3)});
    request(3'd3);
    rd(8'h30, v);
    chk("R4 first match level", v, 1);
    chk("R2 odd half src", 32'(act_src), 1);
    request(3'd5);
    rd(8'h30, v);
    chk("R4 level3", v, 3);
    chk("R2 level3 src", 32'(act_src), 3);
  endtask

  task automatic t_nomatch;
    logic [31:0] v;
    request(3'd7);
    chk("R5 nomatch err", 32'(err), 1);
    rd(8'h30, v);
    chk("R5 level kept", v, 3);
  endtask

  task automatic t_step_up;
    logic [31:0] v;
    int n;
    logic [1:0] lv;
    bit odd;
    request(3'd1);
    n = 0; odd = 1'b0;
    while (busy && n < 100) begin
      rd(8'h30, v);
      lv = v[1:0];
      if (lv != 2'd1) odd = 1'b1;
      if (n == 1) begin
        req_valid = 1'b1; req_div = 3'd5;
        bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'd2;
        src_valid = 1'b1; src_sel = 2'd0;
      end
      @(negedge clk);
      req_valid = 1'b0; bus_we = 1'b0; src_valid = 1'b0;
      n++;
    end
    chk("R7 settle length", 32'(n), SETTLE);
    chk("R9 only level 1 during hold", 32'(odd), 0);
    rd(8'h30, v);
    chk("R7 final level", v, 0);
    chk("R8 ignored input no err", 32'(err), 0);
    rd(8'h18, v);
    chk("R8 src write ignored", v[10:9], 1);
  endtask

  task automatic t_direct;
    logic [31:0] v;
    wr(8'h30, 32'd1);
    rd(8'h30, v);
    chk("R3 load write", v, 1);
    request(3'd1);
    rd(8'h30, v);
    chk("R10 direct level", v, 0);
    chk("R10 direct no busy", 32'(busy), 0);
  endtask

  task automatic t_disabled_req;
    logic [31:0] v;
    wr(8'h24, 32'h0);
    request(3'd3);
    chk("R5 disabled err", 32'(err), 1);
    rd(8'h30, v);
    chk("R5 disabled level kept", v, 0);
    chk("R3 static back", 32'(act_div), 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_static();
    t_src_broadcast();
    t_enable();
    t_src_rejected();
    t_req_unique();
    t_req_first_match();
    t_nomatch();
    t_step_up();
    t_direct();
    t_disabled_req();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule